// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer with separate write and read clocks. By default it holds 256 words of 18 bits. One side of the logic stores words on the write clock and the other delivers them on the read clock. Both enables are active-low. The block reports empty, full, half-full, almost-empty and almost-full status, and every flag is active-low. Each flag is generated from registers in the clock domain of the side that consumes it. The two pointers cross between domains as Gray codes through two-flop synchronizers.

The almost-empty and almost-full thresholds are held in two offset registers. These are accessed over the normal data buses while the load control is low. A write-side access stores the low bits of the input bus, and a read-side access returns the stored value on the output bus. Each side has its own toggle, which visits the almost-empty offset first and the almost-full offset second. A retransmit strobe on the read side moves the read point back to the first word written since reset, so that data already read can be read again.

The reset input is asynchronous. It empties the buffer, sets both offsets to 7 and points both toggles at the almost-empty offset.

Top module: `dcfifo_pflag`

## Requirements
- R1: On a rising `wclk_i` edge with `wen_ni` low, `load_ni` high and `full_no` high, `din_i` is stored. Words are delivered in the order they were stored.
- R2: On a rising `rclk_i` edge with `ren_ni` low, `load_ni` high and `empty_no` high, the oldest word appears on `dout_o` after that edge. A read attempted while `empty_no` is low leaves `dout_o` unchanged.
- R3: `full_no` is low exactly when 256 words are held. A write attempted while full is ignored and does not overwrite any stored word. `full_no` returns high within three `wclk_i` edges after a read frees a location.
- R4: `empty_no` is low exactly when no words are held. It rises within three `rclk_i` edges after the first write and falls in the edge that reads the last word.
- R5: `aempty_no` (read domain) is low when the held word count is less than or equal to the almost-empty offset.
- R6: `afull_no` (write domain) is low when the number of free locations is less than or equal to the almost-full offset.
- R7: `half_no` (write domain) is low when more than 128 words are held.
- R8: An offset load occurs when `load_ni` and `wen_ni` are both low at a `wclk_i` edge. It stores `din_i[7:0]` into the almost-empty offset on the first load after reset and into the almost-full offset on the second, then alternates. The buffer contents are unaffected.
- R9: An offset read-back occurs when `load_ni` and `ren_ni` are both low at an `rclk_i` edge. It drives the selected offset onto `dout_o[7:0]`, with zeros in bits 17:8. The read-back alternates almost-empty first, then almost-full.
- R10: While `rst_ni` is low, the block resets with no clock: the buffer is emptied, both offsets are set to 7, and both toggles point at the almost-empty offset. After reset, `empty_no=0`, `aempty_no=0`, `full_no=1`, `afull_no=1` and `half_no=1`.
- R11: `retx_i` high at an `rclk_i` edge moves the read point to the first word written since reset. This takes priority over a read in the same edge. The following reads repeat the earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active-low |
| wen_ni | input | 1 | Write enable, active-low |
| ren_ni | input | 1 | Read enable, active-low |
| load_ni | input | 1 | Offset register access select, active-low |
| retx_i | input | 1 | Retransmit strobe, read clock domain |
| din_i | input | 18 | Write data / offset load data |
| dout_o | output | 18 | Read data / offset read-back |
| empty_no | output | 1 | Empty flag, read domain |
| aempty_no | output | 1 | Almost-empty flag, read domain |
| full_no | output | 1 | Full flag, write domain |
| afull_no | output | 1 | Almost-full flag, write domain |
| half_no | output | 1 | Half-full flag, write domain |

## Verification
The assertions take three things for granted about the inputs:
- The offsets change only while the read side is idle, because the almost-empty offset is written in the write domain and used in the read domain.
- `retx_i` is pulsed only while the write side is idle and no more than 256 words have been written since reset, because a rewind moves the read pointer by more than one Gray step.
- `load_ni` is never low while the enable on the other side is active.

The stimulus meets all three. It loads offsets only between transfers, applies retransmit just after reset with four words written, and pulses each enable on one side at a time. After every write burst it waits several read-clock edges before it samples a read-domain flag.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr
  import dcfifo_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned OFS_RST = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic          load_ni,
  input  logic [AW-1:0] ofs_din_i,
  input  logic [AW:0]   rgray_s_i,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   wgray_o,
  output logic          we_o,
  output logic [AW-1:0] ae_ofs_o,
  output logic [AW-1:0] af_ofs_o,
  output logic          full_no,
  output logic          afull_no,
  output logic          half_no
);
  localparam logic [AW:0]   DEPTH_V = (AW+1)'(1 << AW);
  localparam logic [AW-1:0] OFS_V   = AW'(OFS_RST);

  logic [AW:0] wptr_q, wgray_q, rbin, count, free, wnext;
  logic [AW-1:0] ae_q, af_q;
  ofs_sel_e sel_q;
  logic full, ld;

  always_comb begin
    rbin[AW] = rgray_s_i[AW];
    for (int i = AW - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s_i[i];
  end

  assign count = wptr_q - rbin;
  assign free  = DEPTH_V - count;
  assign full  = (count == DEPTH_V);
  assign we_o  = !wen_ni && load_ni && !full;
  assign ld    = !wen_ni && !load_ni;
  assign wnext = wptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      ae_q    <= OFS_V;
      af_q    <= OFS_V;
      sel_q   <= SEL_AE;
    end else begin
      if (we_o) begin
        wptr_q  <= wnext;
        wgray_q <= wnext ^ (wnext >> 1);
      end
      if (ld) begin
        if (sel_q == SEL_AE) ae_q <= ofs_din_i;
        else                 af_q <= ofs_din_i;
        sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end

  assign wptr_o   = wptr_q;
  assign wgray_o  = wgray_q;
  assign ae_ofs_o = ae_q;
  assign af_ofs_o = af_q;
  assign full_no  = !full;
  assign afull_no = !(free <= {1'b0, af_q});
  assign half_no  = !(count > (DEPTH_V >> 1));
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
  import dcfifo_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_ni,
  input  logic          load_ni,
  input  logic          retx_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i,
  output logic [AW:0]   rptr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] dout_o,
  output logic          empty_no,
  output logic          aempty_no
);
  logic [AW:0] rptr_q, rgray_q, wbin, count, rnext;
  logic [DW-1:0] dout_q;
  ofs_sel_e sel_q;
  logic empty, re, ld;

  always_comb begin
    wbin[AW] = wgray_s_i[AW];
    for (int i = AW - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s_i[i];
  end

  assign count = wbin - rptr_q;
  assign empty = (count == '0);
  assign re    = !ren_ni && load_ni && !empty && !retx_i;
  assign ld    = !ren_ni && !load_ni;
  assign rnext = rptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      sel_q   <= SEL_AE;
    end else begin
      if (retx_i) begin
        rptr_q  <= '0;
        rgray_q <= '0;
      end else if (re) begin
        rptr_q  <= rnext;
        rgray_q <= rnext ^ (rnext >> 1);
      end
      if (re) begin
        dout_q <= rdata_i;
      end else if (ld) begin
        dout_q <= {{(DW-AW){1'b0}}, (sel_q == SEL_AE) ? ae_ofs_i : af_ofs_i};
        sel_q  <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end

  assign rptr_o    = rptr_q;
  assign rgray_o   = rgray_q;
  assign dout_o    = dout_q;
  assign empty_no  = !empty;
  assign aempty_no = !(count <= {1'b0, ae_ofs_i});
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 18,
  parameter int unsigned OFS_RST = 7
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic          ren_ni,
  input  logic          load_ni,
  input  logic          retx_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_no,
  output logic          aempty_no,
  output logic          full_no,
  output logic          afull_no,
  output logic          half_no
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr, rptr, wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic          we;
  logic [DW-1:0] rdata;

  dcfifo_wr #(.AW(AW), .OFS_RST(OFS_RST)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_ni(wen_ni), .load_ni(load_ni),
    .ofs_din_i(din_i[AW-1:0]), .rgray_s_i(rgray_s), .wptr_o(wptr),
    .wgray_o(wgray), .we_o(we), .ae_ofs_o(ae_ofs), .af_ofs_o(af_ofs),
    .full_no(full_no), .afull_no(afull_no), .half_no(half_no)
  );

  dcfifo_sync #(.W(AW+1)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  dcfifo_sync #(.W(AW+1)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  always_ff @(posedge wclk_i) begin
    if (we) mem[wptr[AW-1:0]] <= din_i;
  end

  assign rdata = mem[rptr[AW-1:0]];

  dcfifo_rd #(.AW(AW), .DW(DW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren_ni(ren_ni), .load_ni(load_ni),
    .retx_i(retx_i), .wgray_s_i(wgray_s), .rdata_i(rdata),
    .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs), .rptr_o(rptr), .rgray_o(rgray),
    .dout_o(dout_o), .empty_no(empty_no), .aempty_no(aempty_no)
  );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int unsigned AW = 8
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wen_ni,
  input logic        load_ni,
  input logic        retx_i,
  input logic        empty_no,
  input logic        aempty_no,
  input logic        full_no,
  input logic        afull_no,
  input logic        half_no,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr
);
  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!full_no && !wen_ni) |=> $stable(wptr));

  assert_no_underflow_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!empty_no && !retx_i) |=> $stable(rptr));

  assert_load_holds_wptr_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !load_ni |=> $stable(wptr));

  assert_empty_in_aempty_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);

  assert_full_in_afull_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);

  assert_full_in_half_R7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !half_no);

  assert_retx_rewinds_R11: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    retx_i |=> (rptr == '0));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wen_ni(wen_ni),
  .load_ni(load_ni), .retx_i(retx_i), .empty_no(empty_no),
  .aempty_no(aempty_no), .full_no(full_no), .afull_no(afull_no),
  .half_no(half_no), .wptr(wptr), .rptr(rptr)
);

// File: tb/dcfifo_pflag_test.sv
module dcfifo_pflag_test;
  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, load_n = 1'b1, retx = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic empty_n, aempty_n, full_n, afull_n, half_n;

  int n_tests = 0, n_fail = 0;
  logic [17:0] sb[$];
  logic [17:0] held;

  dcfifo_pflag uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wen_ni(wen_n),
    .ren_ni(ren_n), .load_ni(load_n), .retx_i(retx), .din_i(din),
    .dout_o(dout), .empty_no(empty_n), .aempty_no(aempty_n),
    .full_no(full_n), .afull_no(afull_n), .half_no(half_n)
  );

  always #5 wclk = ~wclk;
  initial begin
    #3;
    forever #5 rclk = ~rclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #17;
    rst_n = 1'b1;
    sb.delete();
  endtask

  // driver: store one word, record it when acceptance is expected
  task automatic wr(input logic [17:0] d, input bit keep);
    @(negedge wclk);
    wen_n = 1'b0;
    din = d;
    @(posedge wclk);
    #1 wen_n = 1'b1;
    if (keep) sb.push_back(d);
  endtask

  // monitor: read one word and compare with the oldest recorded item
  task automatic rd(input string req);
    logic [17:0] e;
    @(negedge rclk);
    ren_n = 1'b0;
    @(posedge rclk);
    #1 ren_n = 1'b1;
    e = sb.pop_front();
    chk(req, int'(dout), int'(e));
  endtask

  task automatic ld_wr(input logic [17:0] d);
    @(negedge wclk);
    load_n = 1'b0;
    wen_n = 1'b0;
    din = d;
    @(posedge wclk);
    #1;
    wen_n = 1'b1;
    load_n = 1'b1;
  endtask

  task automatic ld_rd(input string req, input int exp);
    @(negedge rclk);
    load_n = 1'b0;
    ren_n = 1'b0;
    @(posedge rclk);
    #1;
    ren_n = 1'b1;
    load_n = 1'b1;
    chk(req, int'(dout), exp);
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wclk);
    @(negedge wclk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge wclk);
    chk("R10 empty", int'(empty_n), 0);
    chk("R10 aempty", int'(aempty_n), 0);
    chk("R10 full", int'(full_n), 1);
    chk("R10 afull", int'(afull_n), 1);
    chk("R10 half", int'(half_n), 1);
    ld_rd("R10/R9 ae reset", 7);
    ld_rd("R10/R9 af reset", 7);

    for (int i = 0; i < 4; i++) wr(18'h2A000 + 18'(i * 17), 1'b1);
    wait_r(4);
    chk("R4 not empty", int'(empty_n), 1);
    for (int i = 0; i < 4; i++) rd("R1/R2 data");
    @(negedge rclk);
    chk("R4 empty after last read", int'(empty_n), 0);
    held = dout;
    @(negedge rclk);
    ren_n = 1'b0;
    @(posedge rclk);
    #1 ren_n = 1'b1;
    chk("R2 read on empty ignored", int'(dout), int'(held));

    @(negedge rclk);
    retx = 1'b1;
    @(posedge rclk);
    #1 retx = 1'b0;
    for (int i = 0; i < 4; i++) sb.push_back(18'h2A000 + 18'(i * 17));
    @(negedge rclk);
    chk("R11 refilled", int'(empty_n), 1);
    for (int i = 0; i < 4; i++) rd("R11 replay");

    do_reset();
    ld_wr(18'h3FF03);
    ld_wr(18'h00005);
    ld_rd("R8/R9 ae", 3);
    ld_rd("R8/R9 af", 5);
    wait_r(4);
    chk("R8 buffer untouched", int'(empty_n), 0);
    for (int i = 0; i < 3; i++) wr(18'h15500 + 18'(i), 1'b1);
    wait_r(4);
    chk("R5 count3 empty", int'(empty_n), 1);
    chk("R5 count3<=3", int'(aempty_n), 0);
    wr(18'h15503, 1'b1);
    wait_r(4);
    chk("R5 count4>3", int'(aempty_n), 1);
    for (int i = 0; i < 4; i++) rd("R1 data");
    wait_w(4);

    for (int i = 1; i <= 256; i++) begin
      wr(18'((i * 1031) ^ 18'h2C3C3), 1'b1);
      @(negedge wclk);
      if (i == 128) chk("R7 count128", int'(half_n), 1);
      if (i == 129) chk("R7 count129", int'(half_n), 0);
      if (i == 250) chk("R6 free6", int'(afull_n), 1);
      if (i == 251) chk("R6 free5", int'(afull_n), 0);
      if (i == 255) chk("R3 count255", int'(full_n), 1);
      if (i == 256) chk("R3 count256", int'(full_n), 0);
    end
    wr(18'h3FFFF, 1'b0);
    wait_r(4);
    chk("R5 full not aempty", int'(aempty_n), 1);
    for (int i = 0; i < 256; i++) rd("R3/R1 no overwrite");
    @(negedge rclk);
    chk("R4 empty after drain", int'(empty_n), 0);
    chk("R3 no extra word", sb.size(), 0);
    wait_w(4);
    chk("R3 full released", int'(full_n), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule